// File: doc/BRIEF.md
# Programmable-Skew Clock Bank Generator

This block produces four banks of two clock outputs from a timing-unit clock, `clk_tu`, whose period is one skew unit. A free-running phase counter stands in for the reference clock and sets the nominal output period. Each bank has a two-digit ternary select code. The code picks one of three behaviours: a lead or lag of whole timing units, a divide-by-2 or divide-by-4 output, or an output inverted relative to the zero-skew wave. Both outputs of a bank always carry the same wave.

A range select sets the period length. An edge select chooses whether outputs line up with the rising or the falling edge of the reference. A synchronous stop request parks every bank except bank 2 at a hold level, and a test mode can disable individual banks. When the test mode asks for bypass, the sampled `ref_in` drives the banks through a tapped delay line, and the skew selections still apply. Ternary levels arrive already encoded as two-bit values, and the code 2'b11 counts as MID.

Top module: `skew_clock_banks`

## Requirements
- R1: Ternary values are encoded as 00 = LOW, 01 = MID, 10 = HIGH, and 11 is read as MID. `range_sel` HIGH, MID and LOW give a period of 8, 16 and 32 tU. The phase counter wraps to 0 once it reaches period-1.
- R2: A bank code is hi digit `bank_sel[4b+3:4b+2]` and lo digit `bank_sel[4b+1:4b]`, with index = 3*hi+lo. For banks 1 and 2, index 0..8 gives a skew of index-4 tU. In counter mode with `edge_pos`=1, the zero-skew output is high for the first half of each period. An output with skew s is that wave delayed by s tU, modulo the period. All outputs are registered, so a phase value shows one clock later.
- R3: For banks 3 and 4, indices 1..7 give a skew of 2*(index-4) tU, that is -6 to +6 in steps of 2.
- R4: Index 0 (LL) makes banks 3 and 4 divide by 2, and index 8 (HH) makes bank 3 divide by 4. A 2-bit beat counter advances at each reference period start. The divide-by-2 output is high when bit 0 is 0, and the divide-by-4 output is high when bit 1 is 0, so their rising edges coincide.
- R5: Index 8 makes bank 4 the complement of the zero-skew output.
- R6: With `edge_pos`=0, the reference falls at the start of the period. The zero-skew output is then low for the first half. Dividers still step at that falling edge.
- R7: While `stop_req` is 1, banks 1, 3 and 4 are held at their hold level, and bank 2 keeps running. The hold level is ~`edge_pos`, except for an inverted bank 4, whose hold level is `edge_pos`.
- R8: When `test_sel` is MID and `stop_req` is 1, any bank with index 0 is held at ~`edge_pos`, bank 2 included. The counter keeps driving every other bank with its normal selection.
- R9: A bank enters or leaves the stopped state only on a cycle where its live value already equals its hold level, so no shortened pulse is produced.
- R10: `test_sel` MID or HIGH selects bypass, except in the R8 case. In bypass, the zero-skew output equals `ref_in` as sampled 7 rising edges earlier, skew s adds s edges of delay, and the dividers step on the matching edge of that delayed reference.
- R11: A low `rst_n` at a clock edge clears the counter, the beat counter, the delay line and the stop state, and drives each output to its hold level. Outputs stay at their hold levels until the counter first completes a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tu | input | 1 | Timing-unit clock, one tU per period |
| rst_n | input | 1 | Synchronous active-low reset |
| range_sel | input | 2 | Ternary period select |
| test_sel | input | 2 | Ternary test mode (bypass / bank disable) |
| edge_pos | input | 1 | 1: rising-edge alignment, 0: falling-edge alignment |
| stop_req | input | 1 | Synchronous stop for all banks except bank 2 |
| ref_in | input | 1 | Reference used in bypass mode |
| bank_sel | input | 16 | Four 4-bit ternary bank codes, bank 1 in bits 3:0 |
| clk_out | output | 8 | Bank outputs, bank b in bits 2b+1:2b |

## Verification
The bench steps every code through all nine levels on every bank under both edge polarities and all three ranges. An off-by-one skew table or a wrong period would show up as shifted edges. It raises and drops the stop request at odd phases. A design that gated immediately would cut a pulse short there, and one that stopped bank 2 would flatten a bank that must keep toggling. The LL-disable test combination is run with bank 2 and bank 3 set to LL, so a design that still divided, or that fell back into bypass, would differ. Bypass runs a slow reference with large skews and catches a wrong tap centre or a wrong edge for the dividers.

// File: rtl/skewgen_pkg.sv
package skewgen_pkg;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  typedef enum logic [1:0] {LANE_SKEW, LANE_DIV2, LANE_DIV4, LANE_INV} lane_kind_e;

  typedef struct packed {
    lane_kind_e         kind;
    logic signed [3:0]  skew;
    logic               is_ll;
  } lane_cfg_t;

  // 2'b11 (or an undriven pin resolved to it) reads as MID
  function automatic logic [1:0] tern_level(input logic [1:0] raw);
    return (raw == 2'b11) ? LVL_MID : raw;
  endfunction

  // index = 3*hi + lo, 0..8
  function automatic logic [3:0] tap_index(input logic [3:0] code);
    logic [3:0] hi, lo;
    hi = {2'b00, tern_level(code[3:2])};
    lo = {2'b00, tern_level(code[1:0])};
    return (hi << 1) + hi + lo;
  endfunction

  function automatic lane_cfg_t decode_lane(input int bank, input logic [3:0] code);
    lane_cfg_t         c;
    logic [3:0]        idx;
    logic signed [4:0] d;
    idx     = tap_index(code);
    d       = $signed({1'b0, idx}) - 5'sd4;
    c.kind  = LANE_SKEW;
    c.is_ll = (idx == 4'd0);
    c.skew  = d[3:0];
    if (bank >= 2) begin
      c.skew = {d[2:0], 1'b0};
      if (idx == 4'd0) begin
        c.kind = LANE_DIV2;
        c.skew = 4'sd0;
      end else if (idx == 4'd8) begin
        c.kind = (bank == 2) ? LANE_DIV4 : LANE_INV;
        c.skew = 4'sd0;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer
  import skewgen_pkg::*;
#(
  parameter int SHORT_PERIOD = 8,
  parameter int CW = $clog2(4 * SHORT_PERIOD),
  parameter int PW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    range_sel,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] period_o,
  output logic          armed_o
);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          at_last_w;
  logic          past_last_w;

  always_comb begin
    case (tern_level(range_sel))
      LVL_HIGH: period_o = PW'(SHORT_PERIOD);
      LVL_MID:  period_o = PW'(2 * SHORT_PERIOD);
      default:  period_o = PW'(4 * SHORT_PERIOD);
    endcase
  end

  assign at_last_w   = (PW'(cnt_q) == period_o - PW'(1));
  assign past_last_w = (PW'(cnt_q) >= period_o - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q <= past_last_w ? '0 : cnt_q + 1'b1;
      if (at_last_w) armed_q <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;

  // R1: the counter returns to zero after the last phase of the period
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(cnt_q) >= period_o - PW'(1)) |=> (cnt_q == '0));

endmodule

// File: rtl/ref_tap.sv
module ref_tap #(
  parameter int CENTER = 6,
  parameter int DEPTH  = 2 * CENTER + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             edge_pos,
  output logic [DEPTH-1:0] hist_o,
  output logic             edge_o
);

  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[DEPTH-2:0], ref_in};
  end

  // active edge of the centre tap: rising for edge_pos, falling otherwise
  assign edge_o = edge_pos ? (hist_q[CENTER] & ~hist_q[CENTER+1])
                           : (~hist_q[CENTER] & hist_q[CENTER+1]);
  assign hist_o = hist_q;

endmodule

// File: rtl/bank_lane.sv
module bank_lane
  import skewgen_pkg::*;
#(
  parameter int BANK   = 0,
  parameter int CW     = 5,
  parameter int PW     = CW + 1,
  parameter int CENTER = 6,
  parameter int DEPTH  = 2 * CENTER + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       code_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [PW-1:0]    period_i,
  input  logic [DEPTH-1:0] hist_i,
  input  logic [1:0]       beat_i,
  input  logic             armed_i,
  input  logic             bypass_i,
  input  logic             edge_pos,
  input  logic             stop_req,
  input  logic             test_mid,
  output logic [1:0]       q_o
);

  localparam int TW = $clog2(DEPTH);

  lane_cfg_t     cfg;
  logic [PW-1:0] mask_w, half_w, ph_w, zero_ph_w;
  logic [TW-1:0] tap_w;
  logic          nom_w, zero_w;
  logic          dis_ll_w, want_w, hold_w, live_w, stop_eff_w;
  logic          stopped_q, q_r;

  assign cfg       = decode_lane(BANK, code_i);
  assign mask_w    = period_i - PW'(1);
  assign half_w    = period_i >> 1;
  assign ph_w      = (PW'(cnt_i) - PW'($signed(cfg.skew))) & mask_w;
  assign zero_ph_w = PW'(cnt_i) & mask_w;
  assign tap_w     = TW'(CENTER + int'($signed(cfg.skew)));

  // reference-shaped wave: first half high on rising alignment
  assign nom_w  = bypass_i ? hist_i[tap_w]  : ((ph_w < half_w) == edge_pos);
  assign zero_w = bypass_i ? hist_i[CENTER] : ((zero_ph_w < half_w) == edge_pos);

  assign dis_ll_w = test_mid && stop_req && cfg.is_ll;
  assign want_w   = dis_ll_w || (stop_req && (BANK != 1));
  assign hold_w   = (cfg.kind == LANE_INV && !dis_ll_w) ? edge_pos : ~edge_pos;

  always_comb begin
    case (cfg.kind)
      LANE_DIV2: live_w = ~beat_i[0];
      LANE_DIV4: live_w = ~beat_i[1];
      LANE_INV:  live_w = ~zero_w;
      default:   live_w = nom_w;
    endcase
  end

  // stop state only moves where the output already sits at the hold level
  assign stop_eff_w = (live_w == hold_w) ? want_w : stopped_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
      q_r       <= hold_w;
    end else begin
      stopped_q <= stop_eff_w;
      q_r       <= (!armed_i || stop_eff_w) ? hold_w : live_w;
    end
  end

  assign q_o = {2{q_r}};

  // R7: a stopped bank shows its hold level
  assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_q |-> (q_r == $past(hold_w)));

  // R9: stop state changes only at a hold point
  assert_no_runt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_q != $past(stopped_q)) |-> ($past(live_w) == $past(hold_w)));

  // R11: before the first full period the output stays parked
  assert_prearm_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> (q_r == $past(hold_w)));

endmodule

// File: rtl/skew_clock_banks.sv
module skew_clock_banks
  import skewgen_pkg::*;
#(
  parameter int NB           = 4,
  parameter int SHORT_PERIOD = 8,
  parameter int TAP_CENTER   = 6
) (
  input  logic            clk_tu,
  input  logic            rst_n,
  input  logic [1:0]      range_sel,
  input  logic [1:0]      test_sel,
  input  logic            edge_pos,
  input  logic            stop_req,
  input  logic            ref_in,
  input  logic [4*NB-1:0] bank_sel,
  output logic [2*NB-1:0] clk_out
);

  localparam int CW    = $clog2(4 * SHORT_PERIOD);
  localparam int PW    = CW + 1;
  localparam int DEPTH = 2 * TAP_CENTER + 1;

  logic [CW-1:0]    cnt;
  logic [PW-1:0]    period;
  logic             armed;
  logic [DEPTH-1:0] hist;
  logic             ref_edge;
  logic             test_mid, bypass, beat;
  logic [1:0]       beat_q, beat_next;

  assign test_mid  = (tern_level(test_sel) == LVL_MID);
  assign bypass    = (tern_level(test_sel) != LVL_LOW) && !(test_mid && stop_req);
  assign beat      = bypass ? ref_edge : (cnt == '0);
  assign beat_next = beat_q + {1'b0, beat};

  always_ff @(posedge clk_tu) begin
    if (!rst_n) beat_q <= 2'b00;
    else        beat_q <= beat_next;
  end

  phase_timer #(.SHORT_PERIOD(SHORT_PERIOD), .CW(CW), .PW(PW)) u_timer (
    .clk(clk_tu), .rst_n(rst_n), .range_sel(range_sel),
    .cnt_o(cnt), .period_o(period), .armed_o(armed)
  );

  ref_tap #(.CENTER(TAP_CENTER), .DEPTH(DEPTH)) u_tap (
    .clk(clk_tu), .rst_n(rst_n), .ref_in(ref_in), .edge_pos(edge_pos),
    .hist_o(hist), .edge_o(ref_edge)
  );

  for (genvar b = 0; b < NB; b++) begin : g_lane
    bank_lane #(.BANK(b), .CW(CW), .PW(PW), .CENTER(TAP_CENTER), .DEPTH(DEPTH)) u_lane (
      .clk(clk_tu), .rst_n(rst_n), .code_i(bank_sel[4*b +: 4]),
      .cnt_i(cnt), .period_i(period), .hist_i(hist), .beat_i(beat_next),
      .armed_i(armed), .bypass_i(bypass), .edge_pos(edge_pos),
      .stop_req(stop_req), .test_mid(test_mid), .q_o(clk_out[2*b +: 2])
    );
  end

endmodule

// File: tb/skew_clock_banks_test.sv
module skew_clock_banks_test;

  localparam int CP     = 10;
  localparam int CENTER = 6;
  localparam int DEPTH  = 2 * CENTER + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  range_sel = 2'b10;
  logic [1:0]  test_sel = 2'b00;
  logic        edge_pos = 1'b1;
  logic        stop_req = 1'b0;
  logic        ref_in = 1'b0;
  logic [15:0] bank_sel = 16'h5555;
  logic [7:0]  clk_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit ref_on = 0;
  int ref_half = 5;

  skew_clock_banks uut (
    .clk_tu(clk), .rst_n(rst_n), .range_sel(range_sel), .test_sel(test_sel),
    .edge_pos(edge_pos), .stop_req(stop_req), .ref_in(ref_in),
    .bank_sel(bank_sel), .clk_out(clk_out)
  );

  always #(CP/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int   m_cnt = 0;
  int   m_pc = 0;
  bit   m_armed = 0;
  bit   refh[DEPTH];
  bit   m_stop[4];
  logic [7:0] m_q = 8'h00;

  function automatic int tern(input logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic int period_of(input logic [1:0] r);
    case (tern(r))
      0: return 32;
      1: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic bit level_at(input int t, input int p, input bit rise);
    int ph;
    ph = ((t % p) + p) % p;
    return rise ? (ph < p / 2) : !(ph < p / 2);
  endfunction

  always @(posedge clk) begin
    int  p, pcn, idx, kind, s;
    bit  byp, ev, dis, want, hold, live, eff;
    cyc++;
    p   = period_of(range_sel);
    byp = (tern(test_sel) != 0) && !(tern(test_sel) == 1 && stop_req);
    if (byp) ev = edge_pos ? (refh[CENTER] && !refh[CENTER+1]) : (!refh[CENTER] && refh[CENTER+1]);
    else     ev = (m_cnt == 0);
    pcn = (m_pc + (ev ? 1 : 0)) % 4;
    for (int b = 0; b < 4; b++) begin
      idx  = 3 * tern(bank_sel[4*b+2 +: 2]) + tern(bank_sel[4*b +: 2]);
      kind = 0;
      s    = idx - 4;
      if (b >= 2) begin
        s = 2 * (idx - 4);
        if (idx == 0) begin kind = 1; s = 0; end
        if (idx == 8) begin kind = (b == 2) ? 2 : 3; s = 0; end
      end
      dis  = (tern(test_sel) == 1) && stop_req && (idx == 0);
      want = dis || (stop_req && b != 1);
      hold = (kind == 3 && !dis) ? edge_pos : !edge_pos;
      case (kind)
        1: live = (pcn % 2) == 0;
        2: live = (pcn / 2) == 0;
        3: live = byp ? !refh[CENTER] : !level_at(m_cnt, p, edge_pos);
        default: live = byp ? refh[CENTER + s] : level_at(m_cnt - s, p, edge_pos);
      endcase
      if (!rst_n) begin
        m_stop[b] = 0;
        m_q[2*b +: 2] = {2{hold}};
      end else begin
        eff = (live == hold) ? want : m_stop[b];
        m_stop[b] = eff;
        m_q[2*b +: 2] = {2{(!m_armed || eff) ? hold : live}};
      end
    end
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_armed = 0;
      for (int i = 0; i < DEPTH; i++) refh[i] = 0;
    end else begin
      if (m_cnt == p - 1) m_armed = 1;
      m_cnt = (m_cnt >= p - 1) ? 0 : m_cnt + 1;
      m_pc  = pcn;
      for (int i = DEPTH - 1; i > 0; i--) refh[i] = refh[i-1];
      refh[0] = ref_in;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: clk_out=%b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(clk_out === m_q, tag, clk_out, m_q);
      if (ref_on) ref_in = ((cyc / ref_half) % 2) == 1;
    end
  endtask

  function automatic logic [3:0] code_of(input int idx);
    logic [1:0] hi, lo;
    hi = 2'(idx / 3);
    lo = 2'(idx % 3);
    return {hi, lo};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    run(3, "R11");
    rst_n = 1'b1;
  endtask

  task automatic measure_period(input int expected, input string tag);
    int last, got;
    bit prev;
    last = -1; got = -1;
    prev = clk_out[0];
    for (int i = 0; i < 200 && got < 0; i++) begin
      @(negedge clk);
      if (clk_out[0] && !prev) begin
        if (last >= 0) got = cyc - last;
        last = cyc;
      end
      prev = clk_out[0];
    end
    checks++;
    if (got != expected) begin
      fails++;
      $display("FAIL %s: period=%0d expected %0d", tag, got, expected);
    end
  endtask

  initial begin
    #(CP * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // R11: reset state and parked outputs during first period
    run(2, "R11");
    @(negedge clk);
    check(clk_out === 8'h00, "R11 reset level", clk_out, 8'h00);
    rst_n = 1'b1;
    run(12, "R11");

    // R1: three ranges plus the 11 code as MID
    run(40, "R1");
    measure_period(8, "R1 high range");
    range_sel = 2'b01; run(70, "R1");
    measure_period(16, "R1 mid range");
    range_sel = 2'b00; run(100, "R1");
    measure_period(32, "R1 low range");
    range_sel = 2'b11; run(70, "R1");
    measure_period(16, "R1 code 11 as mid");

    // R2: banks 1 and 2 through all nine codes
    range_sel = 2'b10;
    for (int idx = 0; idx < 9; idx++) begin
      bank_sel[7:0] = {code_of(8 - idx), code_of(idx)};
      run(24, "R2");
    end
    bank_sel[7:0] = 8'h55;

    // R3 R4 R5: banks 3 and 4 through all nine codes, two ranges
    for (int r = 0; r < 2; r++) begin
      range_sel = (r == 0) ? 2'b10 : 2'b00;
      for (int idx = 0; idx < 9; idx++) begin
        bank_sel[15:8] = {code_of(idx), code_of(idx)};
        run(140, (idx == 0) ? "R4" : (idx == 8) ? "R5" : "R3");
      end
    end

    // R6: falling-edge alignment with mixed selections
    edge_pos = 1'b0;
    range_sel = 2'b01;
    bank_sel = {code_of(8), code_of(0), code_of(2), code_of(6)};
    run(130, "R6");
    bank_sel = {code_of(0), code_of(8), code_of(7), code_of(1)};
    run(130, "R6");
    edge_pos = 1'b1;

    // R7 and R9: stop at an odd phase, bank 2 keeps running
    range_sel = 2'b10;
    bank_sel = {code_of(8), code_of(3), code_of(5), code_of(2)};
    run(13, "R9");
    stop_req = 1'b1;
    run(20, "R9");
    begin
      int ch1, ch2;
      logic [7:0] prev;
      ch1 = 0; ch2 = 0;
      prev = clk_out;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        check(clk_out === m_q, "R7", clk_out, m_q);
        if (clk_out[1:0] != prev[1:0]) ch1++;
        if (clk_out[3:2] != prev[3:2]) ch2++;
        prev = clk_out;
      end
      checks++;
      if (ch1 != 0 || ch2 == 0 || clk_out[1:0] !== 2'b00) begin
        fails++;
        $display("FAIL R7: bank1 changes=%0d bank2 changes=%0d, expected 0 and >0", ch1, ch2);
      end
    end
    run(5, "R9");
    stop_req = 1'b0;
    run(30, "R9");
    edge_pos = 1'b0;
    stop_req = 1'b1;
    run(37, "R7");
    stop_req = 1'b0;
    run(21, "R9");
    edge_pos = 1'b1;

    // R8: test MID with stop disables LL banks, bank 2 included
    test_sel = 2'b01;
    bank_sel = {code_of(4), code_of(0), code_of(0), code_of(6)};
    stop_req = 1'b1;
    run(60, "R8");
    stop_req = 1'b0;
    ref_on = 1;
    run(60, "R10");

    // R10: bypass with slow reference and wide skews
    test_sel = 2'b10;
    ref_half = 7;
    bank_sel = {code_of(1), code_of(7), code_of(8), code_of(0)};
    run(120, "R10");
    bank_sel = {code_of(8), code_of(8), code_of(1), code_of(4)};
    run(120, "R10");
    bank_sel = {code_of(3), code_of(0), code_of(2), code_of(5)};
    run(120, "R10");
    edge_pos = 1'b0;
    run(120, "R10");
    edge_pos = 1'b1;
    ref_on = 0;
    test_sel = 2'b00;

    // R11: reset mid-run parks outputs again
    do_reset();
    run(20, "R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule